// File: doc/BRIEF.md
# Banked Memory Window Address Decoder

This block sits between a 16-bit CPU address bus and the memories of a microcontroller that uses a banked window to reach more storage than 64 KB allows. Every access is steered to one of four targets: the peripheral register space, on-chip RAM, on-chip flash, or the external bus. A 16 KB window in the middle of the address map shows one page of a larger physical space. An 8-bit page register picks that page. Low page numbers reach external memory, a band of sixteen higher numbers reaches on-chip flash, and any value above that band is reserved.

Two flash pages also appear at fixed places outside the window, so the same flash byte can be reached either directly or through the window. For each access the block registers the target selects, an error flag, the physical byte address inside the selected target, and a 20-bit linear address (page times 16 KB plus offset) for debug use. When paged mode is disabled, the page register is pinned to the first flash page and software writes to it have no effect.

Top module: `page_window_decoder`

## Requirements
- R1: A valid access with address 0x0000..0x0FFF asserts `sel_reg`, and `phys_addr` equals the address.
- R2: A valid access with address 0x1000..0x3FFF asserts `sel_ram` in both modes, and `phys_addr` equals the address.
- R3: Addresses 0x4000..0x7FFF assert `sel_flash` with `phys_addr` = 0xE*0x4000 + (address & 0x3FFF), which is the location of page 0x3E. Addresses 0xC000..0xFFFF assert `sel_flash` with `phys_addr` = 0xF*0x4000 + (address & 0x3FFF), which is the location of page 0x3F.
- R4: In the window 0x8000..0xBFFF, an effective page of 0x00..0x2F asserts `sel_ext` with `phys_addr` = page*0x4000 + (address − 0x8000).
- R5: In the window, an effective page of 0x30..0x3F asserts `sel_flash` with `phys_addr` = (page − 0x30)*0x4000 + (address − 0x8000).
- R6: In the window, an effective page of 0x40..0xFF asserts `acc_err`, asserts no select, and drives `phys_addr` and `lin_addr` to 0.
- R7: After reset all selects and `acc_err` are 0, both addresses are 0, and `page_q` is 0x30.
- R8: In paged mode, a `pg_wr_en` pulse loads `pg_wr_data` into the page register at the clock edge. An access in the same cycle still uses the old page, and an access in the next cycle uses the new one.
- R9: While `paged_en` is 0 the effective page is 0x30, `page_q` reads 0x30 after each clock edge, and writes are ignored.
- R10: `lin_addr` is page*0x4000 + offset for window and fixed-flash accesses (the fixed regions use page 0x3E or 0x3F), and equals the address for register and RAM accesses.
- R11: Each valid access produces exactly one of `sel_reg`, `sel_ram`, `sel_flash`, `sel_ext`, `acc_err`. A cycle with `acc_valid` low produces none of them.
- R12: All decode outputs are registered and appear one clock after the access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paged_en | input | 1 | 1 = paged mode, 0 = page pinned to 0x30 |
| pg_wr_en | input | 1 | One-cycle page register write strobe |
| pg_wr_data | input | 8 | Page register write value |
| acc_valid | input | 1 | Access request this cycle |
| acc_addr | input | 16 | CPU address of the access |
| sel_reg | output | 1 | Register space selected |
| sel_ram | output | 1 | On-chip RAM selected |
| sel_flash | output | 1 | On-chip flash selected |
| sel_ext | output | 1 | External bus selected |
| acc_err | output | 1 | Window access with reserved page |
| phys_addr | output | 20 | Byte address within the selected target |
| lin_addr | output | 20 | Linear debug address |
| page_q | output | 8 | Current page register contents |

## Verification
The hardest situations to reach from the ports are the ordering corners around the page register. These are a write and a window access in the same cycle, a write followed at once by an access, and a drop out of paged mode right after a write, when the stored page still holds a non-flash value. The stimulus places these back to back in directed sequences. It then runs a seeded random stream that toggles the mode, writes pages across the external, flash and reserved bands, and concentrates addresses in the window and at every region edge.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_REG   = 3'd1,
    TGT_RAM   = 3'd2,
    TGT_FLASH = 3'd3,
    TGT_EXT   = 3'd4,
    TGT_ERR   = 3'd5
  } target_e;

endpackage

// File: rtl/pwd_page_reg.sv
module pwd_page_reg #(
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paged_en,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_q,
  output logic [PAGE_W-1:0] page_eff
);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= RESET_PAGE;
    end else if (!paged_en) begin
      page_q <= RESET_PAGE;
    end else if (wr_en) begin
      page_q <= wr_data;
    end
  end

  // Non-paged mode pins the visible page even before the register settles.
  assign page_eff = paged_en ? page_q : RESET_PAGE;

endmodule

// File: rtl/pwd_region_decode.sv
module pwd_region_decode
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 14,
  parameter logic [ADDR_W-1:0] REG_END   = 16'h1000,
  parameter logic [ADDR_W-1:0] RAM_END   = 16'h4000,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h8000,
  parameter logic [PAGE_W-1:0] FLASH_BASE = 8'h30,
  parameter logic [PAGE_W-1:0] FLASH_END  = 8'h40,
  parameter logic [PAGE_W-1:0] LOW_ALIAS  = 8'h3E,
  parameter logic [PAGE_W-1:0] HIGH_ALIAS = 8'h3F
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page_eff,
  output target_e           tgt,
  output logic [PAGE_W-1:0] bank_page
);

  localparam int WIN_SIZE = 1 << OFF_W;
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_SIZE);

  logic in_win;
  assign in_win = (addr >= WIN_BASE) && ({1'b0, addr} < WIN_END);

  always_comb begin
    tgt       = TGT_NONE;
    bank_page = '0;
    if (valid) begin
      if (addr < REG_END) begin
        tgt = TGT_REG;
      end else if (addr < RAM_END) begin
        tgt = TGT_RAM;
      end else if (in_win) begin
        bank_page = page_eff;
        if (page_eff < FLASH_BASE)      tgt = TGT_EXT;
        else if (page_eff < FLASH_END)  tgt = TGT_FLASH;
        else                            tgt = TGT_ERR;
      end else if (addr < WIN_BASE) begin
        tgt       = TGT_FLASH;
        bank_page = LOW_ALIAS;
      end else begin
        tgt       = TGT_FLASH;
        bank_page = HIGH_ALIAS;
      end
    end
  end

endmodule

// File: rtl/pwd_addr_gen.sv
module pwd_addr_gen
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 14,
  parameter int PHYS_W = 20,
  parameter int NUM_FLASH_PAGES = 16,
  parameter logic [PAGE_W-1:0] FLASH_BASE = 8'h30
) (
  input  target_e           tgt,
  input  logic [PAGE_W-1:0] bank_page,
  input  logic [ADDR_W-1:0] addr,
  output logic [PHYS_W-1:0] phys,
  output logic [PHYS_W-1:0] lin
);

  localparam int PG_IDX_W = PHYS_W - OFF_W;
  localparam int FL_IDX_W = $clog2(NUM_FLASH_PAGES);

  logic [OFF_W-1:0]    offset;
  logic [PG_IDX_W-1:0] page_idx;
  logic [FL_IDX_W-1:0] flash_idx;
  logic [PHYS_W-1:0]   paged_lin;

  assign offset    = addr[OFF_W-1:0];
  assign page_idx  = PG_IDX_W'(bank_page);
  assign flash_idx = FL_IDX_W'(bank_page - FLASH_BASE);
  assign paged_lin = {page_idx, offset};

  always_comb begin
    phys = '0;
    lin  = '0;
    unique case (tgt)
      TGT_REG, TGT_RAM: begin
        phys = PHYS_W'(addr);
        lin  = PHYS_W'(addr);
      end
      TGT_EXT: begin
        phys = paged_lin;
        lin  = paged_lin;
      end
      TGT_FLASH: begin
        phys = PHYS_W'({flash_idx, offset});
        lin  = paged_lin;
      end
      default: begin
        phys = '0;
        lin  = '0;
      end
    endcase
  end

endmodule

// File: rtl/page_window_decoder.sv
module page_window_decoder
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 14,
  parameter int PHYS_W = 20,
  parameter int NUM_FLASH_PAGES = 16,
  parameter logic [PAGE_W-1:0] FLASH_BASE = 8'h30,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paged_en,
  input  logic              pg_wr_en,
  input  logic [PAGE_W-1:0] pg_wr_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              sel_reg,
  output logic              sel_ram,
  output logic              sel_flash,
  output logic              sel_ext,
  output logic              acc_err,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [PHYS_W-1:0] lin_addr,
  output logic [PAGE_W-1:0] page_q
);

  localparam logic [PAGE_W-1:0] FLASH_END  = FLASH_BASE + PAGE_W'(NUM_FLASH_PAGES);
  localparam logic [PAGE_W-1:0] HIGH_ALIAS = FLASH_END - PAGE_W'(1);
  localparam logic [PAGE_W-1:0] LOW_ALIAS  = FLASH_END - PAGE_W'(2);

  logic [PAGE_W-1:0] page_eff;
  logic [PAGE_W-1:0] bank_page;
  target_e           tgt;
  logic [PHYS_W-1:0] phys_c;
  logic [PHYS_W-1:0] lin_c;

  pwd_page_reg #(
    .PAGE_W     (PAGE_W),
    .RESET_PAGE (RESET_PAGE)
  ) u_page (
    .clk      (clk),
    .rst      (rst),
    .paged_en (paged_en),
    .wr_en    (pg_wr_en),
    .wr_data  (pg_wr_data),
    .page_q   (page_q),
    .page_eff (page_eff)
  );

  pwd_region_decode #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .OFF_W      (OFF_W),
    .FLASH_BASE (FLASH_BASE),
    .FLASH_END  (FLASH_END),
    .LOW_ALIAS  (LOW_ALIAS),
    .HIGH_ALIAS (HIGH_ALIAS)
  ) u_decode (
    .valid     (acc_valid),
    .addr      (acc_addr),
    .page_eff  (page_eff),
    .tgt       (tgt),
    .bank_page (bank_page)
  );

  pwd_addr_gen #(
    .ADDR_W          (ADDR_W),
    .PAGE_W          (PAGE_W),
    .OFF_W           (OFF_W),
    .PHYS_W          (PHYS_W),
    .NUM_FLASH_PAGES (NUM_FLASH_PAGES),
    .FLASH_BASE      (FLASH_BASE)
  ) u_addr (
    .tgt       (tgt),
    .bank_page (bank_page),
    .addr      (acc_addr),
    .phys      (phys_c),
    .lin       (lin_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_reg   <= 1'b0;
      sel_ram   <= 1'b0;
      sel_flash <= 1'b0;
      sel_ext   <= 1'b0;
      acc_err   <= 1'b0;
      phys_addr <= '0;
      lin_addr  <= '0;
    end else begin
      sel_reg   <= (tgt == TGT_REG);
      sel_ram   <= (tgt == TGT_RAM);
      sel_flash <= (tgt == TGT_FLASH);
      sel_ext   <= (tgt == TGT_EXT);
      acc_err   <= (tgt == TGT_ERR);
      phys_addr <= phys_c;
      lin_addr  <= lin_c;
    end
  end

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int PHYS_W = 20,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 8'h30
) (
  input logic              clk,
  input logic              rst,
  input logic              paged_en,
  input logic              pg_wr_en,
  input logic [PAGE_W-1:0] pg_wr_data,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              sel_reg,
  input logic              sel_ram,
  input logic              sel_flash,
  input logic              sel_ext,
  input logic              acc_err,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [PHYS_W-1:0] lin_addr,
  input logic [PAGE_W-1:0] page_q
);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid)) |->
      ($countones({sel_reg, sel_ram, sel_flash, sel_ext, acc_err}) == 1));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_valid)) |->
      ({sel_reg, sel_ram, sel_flash, sel_ext, acc_err} == 5'b0));

  assert_reserved_page_R6: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> ({sel_reg, sel_ram, sel_flash, sel_ext} == 4'b0 && phys_addr == '0));

  assert_nonpaged_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !paged_en |=> (page_q == RESET_PAGE));

  assert_page_write_R8: assert property (@(posedge clk) disable iff (rst)
    (paged_en && pg_wr_en) |=> (page_q == $past(pg_wr_data)));

  assert_ram_region_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && $past(acc_addr) >= 16'h1000 &&
     $past(acc_addr) < 16'h4000) |->
      (sel_ram && phys_addr == PHYS_W'($past(acc_addr))));

endmodule

bind page_window_decoder pwd_checker i_pwd_checker (.*);

// File: tb/test_page_window_decoder.sv
module test_page_window_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        paged_en = 1'b1;
  logic        pg_wr_en = 1'b0;
  logic [7:0]  pg_wr_data = 8'h00;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic        sel_reg, sel_ram, sel_flash, sel_ext, acc_err;
  logic [19:0] phys_addr, lin_addr;
  logic [7:0]  page_q;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;
  logic [7:0] mpage = 8'h30;

  always #10 clk = ~clk;

  page_window_decoder i_page_window_decoder (
    .clk, .rst, .paged_en, .pg_wr_en, .pg_wr_data, .acc_valid, .acc_addr,
    .sel_reg, .sel_ram, .sel_flash, .sel_ext, .acc_err,
    .phys_addr, .lin_addr, .page_q
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected decode of one access from the written requirements.
  function automatic void model(input logic v, input logic [15:0] a, input logic [7:0] pg,
                                output logic [4:0] sel, output logic [19:0] phys,
                                output logic [19:0] lin, output string req);
    int off;
    int al;
    sel = 5'b0; phys = '0; lin = '0; req = "R11";
    off = int'(a) % 16384;
    if (!v) return;
    if (a < 16'h1000) begin
      sel = 5'b10000; phys = 20'(a); lin = 20'(a); req = "R1";
    end else if (a < 16'h4000) begin
      sel = 5'b01000; phys = 20'(a); lin = 20'(a); req = "R2";
    end else if (a >= 16'h8000 && a < 16'hC000) begin
      if (pg < 8'd48) begin
        sel = 5'b00010; phys = 20'(int'(pg) * 16384 + off); lin = phys; req = "R4";
      end else if (pg < 8'd64) begin
        sel = 5'b00100; phys = 20'((int'(pg) - 48) * 16384 + off);
        lin = 20'(int'(pg) * 16384 + off); req = "R5";
      end else begin
        sel = 5'b00001; req = "R6";
      end
    end else begin
      al = (a < 16'h8000) ? 62 : 63;
      sel = 5'b00100; phys = 20'((al - 48) * 16384 + off);
      lin = 20'(al * 16384 + off); req = "R3";
    end
  endfunction

  // One cycle: drive after a falling edge, check at the next falling edge (R12).
  task automatic step(input logic v, input logic [15:0] a, input logic wr,
                      input logic [7:0] wd, input logic pm);
    logic [4:0] esel;
    logic [19:0] ephys, elin;
    string req;
    acc_valid = v; acc_addr = a; pg_wr_en = wr; pg_wr_data = wd; paged_en = pm;
    model(v, a, pm ? mpage : 8'h30, esel, ephys, elin, req);
    if (!pm) mpage = 8'h30;
    else if (wr) mpage = wd;
    @(negedge clk);
    check(req, "selects", 32'({sel_reg, sel_ram, sel_flash, sel_ext, acc_err}), 32'(esel));
    check(req, "phys_addr", 32'(phys_addr), 32'(ephys));
    check("R10", "lin_addr", 32'(lin_addr), 32'(elin));
    check(pm ? "R8" : "R9", "page_q", 32'(page_q), 32'(mpage));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int seed = 32'h5EED1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "selects", 32'({sel_reg, sel_ram, sel_flash, sel_ext, acc_err}), 32'd0);
    check("R7", "phys_addr", 32'(phys_addr), 32'd0);
    check("R7", "page_q", 32'(page_q), 32'h30);
    rst = 1'b0;

    // Region edges under the reset page (R1, R2, R3, R5)
    step(1, 16'h0000, 0, 0, 1); step(1, 16'h0FFF, 0, 0, 1);
    step(1, 16'h1000, 0, 0, 1); step(1, 16'h3FFF, 0, 0, 1);
    step(1, 16'h4000, 0, 0, 1); step(1, 16'h7FFF, 0, 0, 1);
    step(1, 16'h8000, 0, 0, 1); step(1, 16'hBFFF, 0, 0, 1);
    step(1, 16'hC000, 0, 0, 1); step(1, 16'hFFFF, 0, 0, 1);
    step(0, 16'h8000, 0, 0, 1);                       // R11 idle
    // R8: write with a same-cycle access (old page), then next access (new page)
    step(1, 16'h8123, 1, 8'h2F, 1);
    step(1, 16'h8123, 0, 0, 1);                       // R4 page 0x2F
    step(1, 16'hBFFF, 1, 8'h00, 1);
    step(1, 16'h8001, 1, 8'h40, 1);                   // R4 page 0
    step(1, 16'h9000, 1, 8'hFF, 1);                   // R6 page 0x40
    step(1, 16'h9000, 1, 8'h3E, 1);                   // R6 page 0xFF
    step(1, 16'h8002, 1, 8'h3F, 1);                   // R10 lin 0xF8002
    step(1, 16'h8000, 1, 8'h05, 1);                   // R5 page 0x3F
    // R9: drop out of paged mode right after a write; writes ignored
    step(1, 16'h8010, 1, 8'h07, 0);
    step(1, 16'h8010, 1, 8'h11, 0);
    step(1, 16'h2000, 0, 0, 0);                       // R2 in non-paged mode
    step(1, 16'h8010, 0, 0, 1);                       // still 0x30 in paged mode

    // Seeded random stream
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [7:0] wd;
      int r;
      r = $urandom_range(0, 9);
      a = 16'($urandom);
      if (r < 5) a = 16'h8000 | (a & 16'h3FFF);
      else if (r == 5) a = 16'($urandom_range(0, 1)) ? 16'h0FFF + 16'($urandom_range(0, 1)) : 16'h7FFF + 16'($urandom_range(0, 1));
      wd = 8'($urandom_range(0, 3) == 0 ? $urandom : $urandom_range(0, 63));
      step(1'($urandom_range(0, 7) != 0), a, 1'($urandom_range(0, 3) == 0), wd,
           1'($urandom_range(0, 15) != 0));
    end
    finish_run();
  end

endmodule